// File: doc/BRIEF.md
# Next-PC and Branch Resolution Unit

This combinational unit decides where instruction fetch goes next on a machine whose instructions are all 8 bytes long. It takes the following inputs:

- the current program counter
- the 8-bit opcode
- the two operand register values read for the instruction
- the sign-extended immediate

From these it produces the next program counter, a link value with its write enable, and a flag that says the instruction redirected the flow.

Two unconditional jump-and-link forms are resolved:

- **PC-relative:** the target is the PC plus the immediate, taken as a byte offset.
- **Register-relative:** the target is the PC plus the second operand plus the immediate.

Six conditional branches compare the two operands for equality, inequality, greater-than and less-or-equal, in unsigned or signed order. A taken branch scales its immediate by the instruction size. Every other opcode simply advances to the next instruction. The first operand (`rs_a_i`) is the left side of every comparison. The second operand (`rs_b_i`) is the right side, and it is also the base of the register-relative jump.

Top module: `npc_unit`

## Requirements
- R1: Opcode 0x28 drives `next_pc_o` = pc + imm (byte offset), `taken_o` = 1 and `link_we_o` = 1.
- R2: Opcode 0x29 drives `next_pc_o` = pc + rs_b + imm, `taken_o` = 1 and `link_we_o` = 1.
- R3: Opcode 0x2A is taken when rs_a == rs_b; opcode 0x2B is taken when rs_a != rs_b.
- R4: Opcode 0x2C is taken when rs_a > rs_b unsigned; opcode 0x2D is taken when rs_a > rs_b signed.
- R5: Opcode 0x2E is taken when rs_a <= rs_b unsigned; opcode 0x2F is taken when rs_a <= rs_b signed.
- R6: A taken conditional branch drives `next_pc_o` = pc + imm*8. A conditional branch that is not taken drives pc + 8 with `taken_o` = 0.
- R7: Conditional branches (0x2A to 0x2F) hold `link_we_o` at 0.
- R8: Any opcode outside 0x28 to 0x2F drives `next_pc_o` = pc + 8 with `taken_o` = 0 and `link_we_o` = 0.
- R9: Ordering compares use the full 64-bit unsigned or signed order, including operand pairs whose difference overflows.
- R10: `link_o` always equals pc + 8, and every address sum wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 64 | Address of the current instruction |
| op_i | input | 8 | Opcode |
| rs_a_i | input | 64 | First operand (left side of compares) |
| rs_b_i | input | 64 | Second operand (right side of compares, jump base) |
| imm_i | input | 64 | Sign-extended immediate |
| next_pc_o | output | 64 | Address of the next instruction to fetch |
| link_o | output | 64 | Return address, pc + 8 |
| link_we_o | output | 1 | Write `link_o` to the destination register |
| taken_o | output | 1 | Flow was redirected away from pc + 8 |

## Verification
The in-line assertions assume that the inputs are settled two-state values whenever the combinational logic evaluates. They also assume that the opcode is a full 8-bit code, so any value outside the branch group counts as sequential.

The bench changes all inputs together just after a rising clock edge and samples the outputs at the following falling edge, so every check sees settled values. The operand patterns are chosen at the signed and unsigned boundaries, where a compare that relied only on the sign of the difference would disagree with the true order.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned OP_W = 8;

  typedef enum logic [1:0] {
    CLS_SEQ  = 2'd0,
    CLS_JREL = 2'd1,
    CLS_JREG = 2'd2,
    CLS_BR   = 2'd3
  } flow_cls_e;

  typedef enum logic [2:0] {
    CMP_EQ  = 3'd0,
    CMP_NE  = 3'd1,
    CMP_GTU = 3'd2,
    CMP_GTS = 3'd3,
    CMP_LEU = 3'd4,
    CMP_LES = 3'd5
  } cmp_sel_e;

  localparam logic [OP_W-1:0] OP_JREL = 8'h28;
  localparam logic [OP_W-1:0] OP_JREG = 8'h29;
  localparam logic [OP_W-1:0] OP_BEQ  = 8'h2A;
  localparam logic [OP_W-1:0] OP_BNE  = 8'h2B;
  localparam logic [OP_W-1:0] OP_BGTU = 8'h2C;
  localparam logic [OP_W-1:0] OP_BGTS = 8'h2D;
  localparam logic [OP_W-1:0] OP_BLEU = 8'h2E;
  localparam logic [OP_W-1:0] OP_BLES = 8'h2F;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned OP_WIDTH = OP_W
) (
  input  logic [OP_WIDTH-1:0] op_i,
  output flow_cls_e           cls_o,
  output cmp_sel_e            cmp_o
);
  always_comb begin
    cls_o = CLS_SEQ;
    cmp_o = CMP_EQ;
    unique case (op_i)
      OP_JREL: cls_o = CLS_JREL;
      OP_JREG: cls_o = CLS_JREG;
      OP_BEQ:  begin cls_o = CLS_BR; cmp_o = CMP_EQ;  end
      OP_BNE:  begin cls_o = CLS_BR; cmp_o = CMP_NE;  end
      OP_BGTU: begin cls_o = CLS_BR; cmp_o = CMP_GTU; end
      OP_BGTS: begin cls_o = CLS_BR; cmp_o = CMP_GTS; end
      OP_BLEU: begin cls_o = CLS_BR; cmp_o = CMP_LEU; end
      OP_BLES: begin cls_o = CLS_BR; cmp_o = CMP_LES; end
      default: ;
    endcase
  end

  // branch group occupies the top six codes of the 0x28 block
  always_comb begin
    if (op_i[OP_WIDTH-1:3] == OP_JREL[OP_WIDTH-1:3] && op_i[2:0] >= 3'd2)
      assert_branch_class_R7: assert (cls_o == CLS_BR);
    else
      assert_nonbranch_class_R8: assert (cls_o != CLS_BR);
  end
endmodule

// File: rtl/npc_compare.sv
module npc_compare #(
  parameter int unsigned WIDTH = 64
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             eq_o,
  output logic             gtu_o,
  output logic             gts_o
);
  logic sign_diff;

  assign sign_diff = a_i[WIDTH-1] ^ b_i[WIDTH-1];
  assign eq_o      = (a_i == b_i);
  assign gtu_o     = (a_i > b_i);
  // signed order: same-sign pairs follow unsigned order, else positive side wins
  assign gts_o     = sign_diff ? b_i[WIDTH-1] : gtu_o;

  always_comb begin
    if (eq_o)
      assert_eq_not_greater_R4: assert (!gtu_o && !gts_o);
    if (gtu_o != gts_o)
      assert_order_split_sign_R9: assert (a_i[WIDTH-1] != b_i[WIDTH-1]);
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int unsigned WIDTH      = 64,
  parameter int unsigned INSN_BYTES = 8
) (
  input  logic [WIDTH-1:0] pc_i,
  input  logic [WIDTH-1:0] base_i,
  input  logic [WIDTH-1:0] imm_i,
  output logic [WIDTH-1:0] seq_pc_o,
  output logic [WIDTH-1:0] jrel_pc_o,
  output logic [WIDTH-1:0] jreg_pc_o,
  output logic [WIDTH-1:0] br_pc_o
);
  localparam int unsigned SCALE_SH = $clog2(INSN_BYTES);
  localparam logic [WIDTH-1:0] STEP = WIDTH'(INSN_BYTES);

  logic [WIDTH-1:0] imm_scaled;

  assign imm_scaled = imm_i << SCALE_SH;
  assign seq_pc_o   = pc_i + STEP;
  assign jrel_pc_o  = pc_i + imm_i;
  assign jreg_pc_o  = jrel_pc_o + base_i;
  assign br_pc_o    = pc_i + imm_scaled;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned WIDTH      = XLEN,
  parameter int unsigned OP_WIDTH   = OP_W,
  parameter int unsigned INSN_BYTES = 8
) (
  input  logic [WIDTH-1:0]    pc_i,
  input  logic [OP_WIDTH-1:0] op_i,
  input  logic [WIDTH-1:0]    rs_a_i,
  input  logic [WIDTH-1:0]    rs_b_i,
  input  logic [WIDTH-1:0]    imm_i,
  output logic [WIDTH-1:0]    next_pc_o,
  output logic [WIDTH-1:0]    link_o,
  output logic                link_we_o,
  output logic                taken_o
);
  flow_cls_e        cls;
  cmp_sel_e         cmp;
  logic             eq, gtu, gts;
  logic             cond_hit;
  logic [WIDTH-1:0] seq_pc, jrel_pc, jreg_pc, br_pc;

  npc_decode #(.OP_WIDTH(OP_WIDTH)) u_decode (
    .op_i  (op_i),
    .cls_o (cls),
    .cmp_o (cmp)
  );

  npc_compare #(.WIDTH(WIDTH)) u_compare (
    .a_i   (rs_a_i),
    .b_i   (rs_b_i),
    .eq_o  (eq),
    .gtu_o (gtu),
    .gts_o (gts)
  );

  npc_target #(.WIDTH(WIDTH), .INSN_BYTES(INSN_BYTES)) u_target (
    .pc_i      (pc_i),
    .base_i    (rs_b_i),
    .imm_i     (imm_i),
    .seq_pc_o  (seq_pc),
    .jrel_pc_o (jrel_pc),
    .jreg_pc_o (jreg_pc),
    .br_pc_o   (br_pc)
  );

  always_comb begin
    unique case (cmp)
      CMP_EQ:  cond_hit = eq;
      CMP_NE:  cond_hit = !eq;
      CMP_GTU: cond_hit = gtu;
      CMP_GTS: cond_hit = gts;
      CMP_LEU: cond_hit = !gtu;
      CMP_LES: cond_hit = !gts;
      default: cond_hit = 1'b0;
    endcase
  end

  always_comb begin
    next_pc_o = seq_pc;
    taken_o   = 1'b0;
    link_we_o = 1'b0;
    unique case (cls)
      CLS_JREL: begin next_pc_o = jrel_pc; taken_o = 1'b1; link_we_o = 1'b1; end
      CLS_JREG: begin next_pc_o = jreg_pc; taken_o = 1'b1; link_we_o = 1'b1; end
      CLS_BR: if (cond_hit) begin next_pc_o = br_pc; taken_o = 1'b1; end
      default: ;
    endcase
  end

  assign link_o = seq_pc;

  always_comb begin
    if (link_we_o)
      assert_link_implies_jump_R1: assert (taken_o && cls != CLS_BR);
    if (cls == CLS_BR)
      assert_branch_no_link_R7: assert (!link_we_o);
    if (cls == CLS_BR && !taken_o)
      assert_fallthrough_target_R6: assert (next_pc_o == link_o);
    if (cls == CLS_SEQ)
      assert_seq_flow_R8: assert (!taken_o && next_pc_o == link_o);
    if (cls == CLS_BR && eq)
      assert_equal_ops_order_R5: assert (taken_o == (cmp != CMP_NE && cmp != CMP_GTU && cmp != CMP_GTS));
  end
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  typedef struct packed {
    logic [7:0]  op;
    logic [63:0] pc;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] imm;
    logic [63:0] exp_next;
    logic        exp_taken;
    logic        exp_we;
  } vec_t;

  localparam int NV = 16;
  localparam logic [63:0] MINS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXS = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  localparam vec_t VEC [NV] = '{
    '{8'h28, 64'h1000, 64'h0,  64'h0,      64'h40,    64'h1040, 1'b1, 1'b1}, // R1
    '{8'h28, 64'h1000, 64'h0,  64'h0,      -64'sd8,   64'h0FF8, 1'b1, 1'b1}, // R1 R10
    '{8'h29, 64'h1000, 64'h77, 64'h2000,   64'h10,    64'h3010, 1'b1, 1'b1}, // R2
    '{8'h2A, 64'h1000, 64'h5,  64'h5,      64'h3,     64'h1018, 1'b1, 1'b0}, // R3
    '{8'h2A, 64'h1000, 64'h5,  64'h6,      64'h3,     64'h1008, 1'b0, 1'b0}, // R3
    '{8'h2B, 64'h1000, 64'h5,  64'h6,      -64'sd2,   64'h0FF0, 1'b1, 1'b0}, // R3 R6
    '{8'h2B, 64'h1000, 64'h9,  64'h9,      64'h4,     64'h1008, 1'b0, 1'b0}, // R3
    '{8'h2C, 64'h1000, MINS,   64'h1,      64'h4,     64'h1020, 1'b1, 1'b0}, // R4 R9
    '{8'h2D, 64'h1000, MINS,   64'h1,      64'h4,     64'h1008, 1'b0, 1'b0}, // R4 R9
    '{8'h2D, 64'h1000, MAXS,   MINS,       64'h4,     64'h1020, 1'b1, 1'b0}, // R9
    '{8'h2C, 64'h1000, 64'h3,  64'h3,      64'h4,     64'h1008, 1'b0, 1'b0}, // R4
    '{8'h2E, 64'h1000, 64'h3,  64'h3,      64'h4,     64'h1020, 1'b1, 1'b0}, // R5
    '{8'h2F, 64'h1000, ALL1,   64'h0,      64'h4,     64'h1020, 1'b1, 1'b0}, // R5 R9
    '{8'h2E, 64'h1000, ALL1,   64'h0,      64'h4,     64'h1008, 1'b0, 1'b0}, // R5 R9
    '{8'h10, 64'h1000, 64'h1,  64'h1,      64'h40,    64'h1008, 1'b0, 1'b0}, // R8
    '{8'h3A, 64'h2000, 64'h1,  64'h2,      64'h40,    64'h2008, 1'b0, 1'b0}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] pc_i = '0, rs_a_i = '0, rs_b_i = '0, imm_i = '0;
  logic [7:0]  op_i = '0;
  logic [63:0] next_pc_o, link_o;
  logic        link_we_o, taken_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  npc_unit u_npc_unit (
    .pc_i(pc_i), .op_i(op_i), .rs_a_i(rs_a_i), .rs_b_i(rs_b_i), .imm_i(imm_i),
    .next_pc_o(next_pc_o), .link_o(link_o), .link_we_o(link_we_o), .taken_o(taken_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [63:0] pc, a, b, imm);
    @(posedge clk);
    #1;
    op_i = op; pc_i = pc; rs_a_i = a; rs_b_i = b; imm_i = imm;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: idle opcode flows sequentially
    apply(8'h00, 64'h0, 64'h0, 64'h0, 64'h0);
    chk("R8 reset next", next_pc_o, 64'h8);
    chk("R8 reset taken", {63'b0, taken_o}, 64'h0);
    chk("R8 reset link_we", {63'b0, link_we_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].pc, VEC[i].a, VEC[i].b, VEC[i].imm);
      chk($sformatf("R6 vec%0d next", i), next_pc_o, VEC[i].exp_next);
      chk($sformatf("R3 vec%0d taken", i), {63'b0, taken_o}, {63'b0, VEC[i].exp_taken});
      chk($sformatf("R7 vec%0d link_we", i), {63'b0, link_we_o}, {63'b0, VEC[i].exp_we});
      chk($sformatf("R10 vec%0d link", i), link_o, VEC[i].pc + 64'd8);
    end

    // R10: sequential and link wrap at top of address space
    apply(8'h00, 64'hFFFF_FFFF_FFFF_FFF8, 64'h0, 64'h0, 64'h0);
    chk("R10 wrap next", next_pc_o, 64'h0);
    chk("R10 wrap link", link_o, 64'h0);
    // R2: register jump with negative immediate wrapping below zero
    apply(8'h29, 64'h10, 64'h0, 64'h8, -64'sd40);
    chk("R2 neg target", next_pc_o, 64'hFFFF_FFFF_FFFF_FFF0);
    chk("R2 link_we", {63'b0, link_we_o}, 64'h1);
    // R4 signed greater with both negative operands
    apply(8'h2D, 64'h100, -64'sd2, -64'sd5, 64'h2);
    chk("R4 neg gts next", next_pc_o, 64'h110);
    // R9: unsigned views of the same pair
    apply(8'h2C, 64'h100, MAXS, MINS, 64'h2);
    chk("R9 gtu wide", next_pc_o, 64'h108);
    // R5 signed le fails where unsigned le holds
    apply(8'h2F, 64'h100, 64'h1, ALL1, 64'h2);
    chk("R5 les false", {63'b0, taken_o}, 64'h0);
    // R8: opcode just outside the branch group
    apply(8'h30, 64'h100, 64'h1, 64'h1, 64'h2);
    chk("R8 0x30 taken", {63'b0, taken_o}, 64'h0);
    chk("R8 0x30 next", next_pc_o, 64'h108);
    apply(8'h27, 64'h100, 64'h1, 64'h1, 64'h2);
    chk("R8 0x27 link_we", {63'b0, link_we_o}, 64'h0);
    chk("R8 0x27 next", next_pc_o, 64'h108);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule